// File: doc/BRIEF.md
# Bounds-Checked Array Index Calculator

This unit turns an array subscript into a scaled element offset. It takes five signed 32-bit operands: a subscript, a lower bound, an upper bound, an element size and an incoming index. It adds the incoming index to the subscript, multiplies that sum by the element size, and returns the low 32 bits as the outgoing index. While the product is being formed, the subscript is compared against both bounds. If the subscript falls outside the inclusive range, a range trap is raised.

The outgoing index also produces condition flags. Negative and zero follow the result, and overflow and carry are always zero. Chained uses can feed one result back as the next incoming index to build multi-dimensional offsets.

Each operation is framed by a start/busy/done handshake. A sequential shift-add multiplier handles one multiplier bit per cycle, so every operation has the same latency. Fetching the operands, acting on the trap and any memory access belong to the surrounding logic.

Top module: `idx_calc`

## Requirements
- R1: When done is high, `index_out` equals the low 32 bits of (`index_in` + `subscript`) × `elem_size`, with all operands and the sum taken as 32-bit two's complement.
- R2: `range_trap` is high with done when `subscript` is signed-less-than `low_bound`.
- R3: `range_trap` is high with done when `subscript` is signed-greater-than `high_bound`.
- R4: When `low_bound` ≤ `subscript` ≤ `high_bound` (signed), `range_trap` stays low. When the trap fires, `index_out` is still updated with the computed result.
- R5: `flag_n` equals bit 31 of the result and is updated together with done.
- R6: `flag_z` is high exactly when the result is all zeros, and is updated together with done.
- R7: `flag_v` and `flag_c` are always low.
- R8: A start accepted on a clock edge raises done for exactly one cycle, 33 clock edges later. `range_trap` is only ever high in a cycle when done is high.
- R9: `busy` is high from the cycle after an accepted start until done rises. A start seen while busy is high is ignored: it changes neither the result, the trap nor the timing.
- R10: After a synchronous active-low reset, `busy`, `done`, `range_trap`, `flag_n`, `flag_z` and `index_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation when not busy |
| subscript | input | 32 | Signed subscript |
| low_bound | input | 32 | Signed inclusive lower bound |
| high_bound | input | 32 | Signed inclusive upper bound |
| elem_size | input | 32 | Signed element size (multiplier) |
| index_in | input | 32 | Signed incoming index added to the subscript |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| index_out | output | 32 | Computed offset, held until the next completion |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Overflow flag, constant zero |
| flag_c | output | 1 | Carry flag, constant zero |
| range_trap | output | 1 | Subscript out of range, pulses with done |

## Verification
The main sweep runs a small grid of subscripts against every ordering of lower and upper bounds in a narrow window. This places the subscript below, at, inside, at the top of and above the range, so a one-off or unsigned compare in either bound shows up. The sizes and incoming indices across the sweep include negative, zero and positive values, which separates a correct signed product from a sum-only or unsigned path and drives the zero and negative flags both ways. Directed cases add a sum that wraps past the signed maximum, extreme bounds that only a signed compare gets right, and a start issued mid-operation that must leave the first result and its latency untouched.

// File: rtl/idx_calc_pkg.sv
// Package idx_calc_pkg
// Shared width default and flag bundle for the index calculator.
// Assumes: all consumers use the same data width parameter.
package idx_calc_pkg;
    parameter int unsigned IDX_W_DEF = 32;

    typedef struct packed {
        logic neg;
        logic zero;
    } idx_cc_t;
endpackage

// File: rtl/idx_bound_check.sv
// Module idx_bound_check
// Signed compare of a subscript against inclusive lower and upper bounds.
// Assumes: operands are held stable by the caller for the whole operation.
module idx_bound_check #(
    parameter int unsigned W = idx_calc_pkg::IDX_W_DEF
) (
    input  logic [W-1:0] sub_i,
    input  logic [W-1:0] low_i,
    input  logic [W-1:0] high_i,
    output logic         below_o,
    output logic         above_o
);
    // Two's complement ordering against each bound
    always_comb begin
        below_o = $signed(sub_i) < $signed(low_i);
        above_o = $signed(sub_i) > $signed(high_i);
    end
endmodule

// File: rtl/idx_flag_gen.sv
// Module idx_flag_gen
// Derives negative and zero condition flags from a result word.
// Assumes: the input is the final truncated result.
module idx_flag_gen #(
    parameter int unsigned W = idx_calc_pkg::IDX_W_DEF
) (
    input  logic [W-1:0]            val_i,
    output idx_calc_pkg::idx_cc_t   cc_o
);
    // Sign bit and all-zero detect
    always_comb begin
        cc_o.neg  = val_i[W-1];
        cc_o.zero = ~|val_i;
    end
endmodule

// File: rtl/idx_shift_mult.sv
// Module idx_shift_mult
// Sequential shift-add multiplier keeping the low W bits of the product.
// One multiplier bit per cycle, W cycles after load; valid_o pulses once.
// Assumes: load is only raised while the unit is idle.
module idx_shift_mult #(
    parameter int unsigned W = idx_calc_pkg::IDX_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [W-1:0] prod_o,
    output logic         valid_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  acc_q, mcand_q, mplier_q, acc_nxt;
    logic [CW-1:0] cnt_q;
    logic          run_q, valid_q;

    // Conditional add of the shifted multiplicand for the current bit
    always_comb begin
        acc_nxt = mplier_q[0] ? (acc_q + mcand_q) : acc_q;
    end

    // Load, iterate and flag the final step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (load_i) begin
                acc_q    <= '0;
                mcand_q  <= mcand_i;
                mplier_q <= mplier_i;
                cnt_q    <= '0;
                run_q    <= 1'b1;
            end else if (run_q) begin
                acc_q    <= acc_nxt;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign prod_o  = acc_q;
    assign valid_o = valid_q;

    a_r8_mult_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    a_r9_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !run_q);
    a_r8_valid_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !run_q);
endmodule

// File: rtl/idx_calc.sv
// Module idx_calc
// Top: accepts operands on start, forms (index_in + subscript) * elem_size
// through the shift-add multiplier, checks subscript against both bounds and
// registers result, flags and trap with a one-cycle done pulse.
// Assumes: operands are valid in the cycle start is sampled.
module idx_calc #(
    parameter int unsigned W = idx_calc_pkg::IDX_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] subscript,
    input  logic [W-1:0] low_bound,
    input  logic [W-1:0] high_bound,
    input  logic [W-1:0] elem_size,
    input  logic [W-1:0] index_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] index_out,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c,
    output logic         range_trap
);
    logic         accept;
    logic         busy_q, done_q, trap_q, n_q, z_q;
    logic [W-1:0] res_q, sub_q, low_q, high_q;
    logic [W-1:0] sum_in, prod;
    logic         prod_valid, below, above;
    idx_calc_pkg::idx_cc_t cc;

    // Accept a new operation only when idle
    always_comb begin
        accept = start && !busy_q;
        sum_in = index_in + subscript;
    end

    idx_shift_mult #(.W(W)) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .mcand_i  (sum_in),
        .mplier_i (elem_size),
        .prod_o   (prod),
        .valid_o  (prod_valid)
    );

    idx_bound_check #(.W(W)) u_bound (
        .sub_i   (sub_q),
        .low_i   (low_q),
        .high_i  (high_q),
        .below_o (below),
        .above_o (above)
    );

    idx_flag_gen #(.W(W)) u_flags (
        .val_i (prod),
        .cc_o  (cc)
    );

    // Capture bounds operands, track busy and register the completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            trap_q <= 1'b0;
            n_q    <= 1'b0;
            z_q    <= 1'b0;
            res_q  <= '0;
            sub_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                sub_q  <= subscript;
                low_q  <= low_bound;
                high_q <= high_bound;
            end else if (prod_valid) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                res_q  <= prod;
                n_q    <= cc.neg;
                z_q    <= cc.zero;
                trap_q <= below || above;
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign index_out  = res_q;
    assign flag_n     = n_q;
    assign flag_z     = z_q;
    assign flag_v     = 1'b0;
    assign flag_c     = 1'b0;
    assign range_trap = trap_q;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r8_trap_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> done_q);
    a_r9_busy_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !done_q);
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |-> busy_q);
    a_r9_bounds_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> $stable(sub_q) && $stable(low_q) && $stable(high_q));
    a_r5_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (n_q == res_q[W-1]));
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (z_q == (res_q == '0)));
endmodule

// File: tb/idx_calc_tb.sv
`timescale 1ns/1ps
module idx_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] subscript = '0, low_bound = '0, high_bound = '0;
    logic [31:0] elem_size = '0, index_in = '0;
    logic        busy, done, flag_n, flag_z, flag_v, flag_c, range_trap;
    logic [31:0] index_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    idx_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .subscript(subscript), .low_bound(low_bound), .high_bound(high_bound),
        .elem_size(elem_size), .index_in(index_in),
        .busy(busy), .done(done), .index_out(index_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .range_trap(range_trap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one operation and check every output at the done cycle
    task automatic run_op(input int s, input int lo, input int hi, input int sz,
                          input int inx, input bit poke_mid);
        int lat;
        int sum;
        int expv;
        bit exptrap;
        sum     = inx + s;
        expv    = sum * sz;
        exptrap = (s < lo) || (s > hi);
        @(negedge clk);
        subscript = s; low_bound = lo; high_bound = hi;
        elem_size = sz; index_in = inx; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", {31'd0, busy}, 32'd1);
        lat = 0;
        while (!done && lat < 100) begin
            if (poke_mid && lat == 5) begin
                subscript = 32'h7000_0000; low_bound = 32'h7fff_ffff;
                elem_size = 32'd7; index_in = 32'd11; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (!done) chk("R8 no trap before done", {31'd0, range_trap}, 32'd0);
        end
        start = 1'b0;
        chk("R8 latency", lat, 33);
        chk("R1 result", index_out, expv);
        chk("R2/R3/R4 trap", {31'd0, range_trap}, {31'd0, exptrap});
        chk("R5 neg flag", {31'd0, flag_n}, {31'd0, expv < 0});
        chk("R6 zero flag", {31'd0, flag_z}, {31'd0, expv == 0});
        chk("R7 v and c", {30'd0, flag_v, flag_c}, 32'd0);
        chk("R9 busy clear at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R8 done one cycle", {30'd0, done, range_trap}, 32'd0);
        chk("R1 result held", index_out, expv);
        if (poke_mid) begin
            repeat (40) begin
                @(negedge clk);
                if (done || busy) chk("R9 ignored start left no op", 32'd1, 32'd0);
            end
            chk("R9 ignored start result", index_out, expv);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset busy/done/trap", {29'd0, busy, done, range_trap}, 32'd0);
        chk("R10 reset flags", {30'd0, flag_n, flag_z}, 32'd0);
        chk("R10 reset result", index_out, 32'd0);

        // Sweep: subscript against all small bound orderings (R1..R6)
        for (int s = -3; s <= 3; s++)
            for (int lo = -2; lo <= 1; lo++)
                for (int hi = -1; hi <= 2; hi++)
                    run_op(s, lo, hi, (lo * 3) + hi - 1, hi - s - lo, 1'b0);

        // Corner: sum wraps past signed max, extreme bounds (R1, R4, R5)
        run_op(32'h7fff_ffff, 32'h8000_0000, 32'h7fff_ffff, 3, 1, 1'b0);
        // Corner: subscript at most-negative, bounds near zero (R2)
        run_op(32'h8000_0000, 0, 10, 2, 5, 1'b0);
        // Corner: large positive subscript above a negative high bound (R3)
        run_op(32'h4000_0000, -100, -1, -5, 0, 1'b0);
        // Corner: zero size gives zero result (R6)
        run_op(4, 0, 10, 0, 9, 1'b0);
        // Trap with result still written (R4)
        run_op(20, 0, 10, 6, 3, 1'b0);
        // Start while busy is ignored (R9)
        run_op(2, 0, 5, 12, 1, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule